// File: doc/BRIEF.md
# Byte-Lane Static Memory Core with Three-Way Select

This block is a word-organized static memory for use inside a larger chip. Each word is 24 bits wide and split into three 8-bit lanes. The block decodes its control pins without a clock: three chip selects (two active-low and one active-high), an active-low write strobe, an active-low output enable and one active-low enable per lane. From these it decides whether the cycle is a write, a read, an output-disabled access or a standby cycle.

There is no tri-state bus. Data enters on a write port and leaves on a read port. A three-bit drive vector says which read lanes are valid, and any lane that is not driven reads as zero. A standby flag goes high whenever the block is not selected. Writes are committed on the rising edge of the block clock while the write condition holds. Read data follows the address combinationally.

A build parameter removes lane control, so every lane is always enabled. Another parameter sets the address width. The full-size configuration uses a 17-bit address, which gives 131,072 words. The default is kept small so that elaboration stays light.

Top module: `bls_sram_core`

## Requirements
- R1: The store holds 2^ADDR_W words of 24 bits. A committed write is visible on the read port combinationally for the same address. Word 0 and word 2^ADDR_W-1 are distinct locations.
- R2: The block is selected only when cs_a_n=0, cs_b_n=0 and cs_c=1. In any other combination, standby=1, rd_drv=0 and nothing is written.
- R3: When selected with we_n=0, each lane whose lane_en_n bit is 0 is written at the next rising clk edge, whatever the value of oe_n. Lane mapping: lane_en_n[0] covers bits 7:0, lane_en_n[1] covers bits 15:8 and lane_en_n[2] covers bits 23:16. A lane whose bit is 1 keeps its old contents.
- R4: When selected with we_n=1 and oe_n=0, rd_drv[i] equals the inverse of lane_en_n[i], and each driven lane of rd_data shows the stored byte at addr.
- R5: When selected with we_n=1 and oe_n=1 (output disable), rd_drv=0 and standby=0.
- R6: Every lane whose rd_drv bit is 0 reads as 8'h00 on rd_data.
- R7: A selected cycle with lane_en_n=3'b111 keeps standby=0 but writes no lane and drives no lane.
- R8: With LANE_CTRL=0, lane_en_n is ignored. Selected writes store the full word, and selected reads drive all three lanes.
- R9: rst_n is asserted asynchronously and released through two clk stages. While rst_n is low, and on the first rising edge after it rises, no write is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which writes are committed |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b_n | input | 1 | Chip select, active low |
| cs_c | input | 1 | Chip select, active high |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| lane_en_n | input | 3 | Per-lane enables, active low (bit i is lane i) |
| wr_data | input | 24 | Write data |
| rd_data | output | 24 | Read data; undriven lanes read as zero |
| rd_drv | output | 3 | Per-lane read drive indicator |
| standby | output | 1 | High when the block is deselected |

## Verification
The bench builds two copies side by side, both with ADDR_W=10, and drives them with the same stimulus. One copy has LANE_CTRL=1 and the other has LANE_CTRL=0. Because the stimulus is shared, every partial-lane pattern is checked against both the masked and the unmasked behaviour. The small address width makes it cheap to clear every word the bench uses and to reach the top address directly, so the first and last words can both be checked for storage.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int LANE_W  = 8;
  localparam int N_LANES = 3;
  localparam int WORD_W  = LANE_W * N_LANES;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_WRITE = 2'd1,
    MODE_READ  = 2'd2,
    MODE_HIZ   = 2'd3
  } bls_mode_e;
endpackage

// File: rtl/bls_rst_sync.sv
module bls_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic s1_q, s1_d;
  logic ok_q, ok_d;

  always_comb begin
    s1_d = 1'b1;
    ok_d = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      ok_q <= 1'b0;
    end else begin
      s1_q <= s1_d;
      ok_q <= ok_d;
    end
  end

  assign rst_ok = ok_q;
endmodule

// File: rtl/bls_select_dec.sv
module bls_select_dec
  import bls_pkg::*;
(
  input  logic      cs_a_n,
  input  logic      cs_b_n,
  input  logic      cs_c,
  input  logic      we_n,
  input  logic      oe_n,
  output logic      sel,
  output bls_mode_e mode
);
  always_comb begin
    sel = !cs_a_n && !cs_b_n && cs_c;
    if (!sel)       mode = MODE_IDLE;
    else if (!we_n) mode = MODE_WRITE;
    else if (!oe_n) mode = MODE_READ;
    else            mode = MODE_HIZ;
  end
endmodule

// File: rtl/bls_lane_gate.sv
module bls_lane_gate
  import bls_pkg::*;
#(
  parameter int NL        = 3,
  parameter bit LANE_CTRL = 1'b1
) (
  input  bls_mode_e     mode,
  input  logic [NL-1:0] lane_en_n,
  input  logic          wr_ok,
  output logic [NL-1:0] lane_we,
  output logic [NL-1:0] lane_drv
);
  logic [NL-1:0] en;

  generate
    if (LANE_CTRL) begin : g_masked
      assign en = ~lane_en_n;
    end else begin : g_full
      assign en = '1;
    end
  endgenerate

  always_comb begin
    lane_we  = (mode == MODE_WRITE && wr_ok) ? en : '0;
    lane_drv = (mode == MODE_READ) ? en : '0;
  end
endmodule

// File: rtl/bls_lane_bank.sv
module bls_lane_bank #(
  parameter int ADDR_W = 10,
  parameter int LW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LW-1:0]     wd,
  output logic [LW-1:0]     rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
  end

  assign rd = mem[addr];

  // R3: a lane write is stored at the addressed word
  assert_lane_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(addr)] == $past(wd)));
endmodule

// File: rtl/bls_sram_core.sv
module bls_sram_core
  import bls_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter bit LANE_CTRL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs_a_n,
  input  logic              cs_b_n,
  input  logic              cs_c,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [2:0]        lane_en_n,
  input  logic [23:0]       wr_data,
  output logic [23:0]       rd_data,
  output logic [2:0]        rd_drv,
  output logic              standby
);
  logic          sel;
  logic          rst_ok;
  bls_mode_e     mode;
  logic [N_LANES-1:0] lane_we;
  logic [N_LANES-1:0] lane_drv;

  bls_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  bls_select_dec u_dec (
    .cs_a_n (cs_a_n),
    .cs_b_n (cs_b_n),
    .cs_c   (cs_c),
    .we_n   (we_n),
    .oe_n   (oe_n),
    .sel    (sel),
    .mode   (mode)
  );

  bls_lane_gate #(.NL(N_LANES), .LANE_CTRL(LANE_CTRL)) u_gate (
    .mode      (mode),
    .lane_en_n (lane_en_n),
    .wr_ok     (rst_ok),
    .lane_we   (lane_we),
    .lane_drv  (lane_drv)
  );

  generate
    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      logic [LANE_W-1:0] q;
      bls_lane_bank #(.ADDR_W(ADDR_W), .LW(LANE_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (lane_we[i]),
        .addr  (addr),
        .wd    (wr_data[i*LANE_W +: LANE_W]),
        .rd    (q)
      );
      assign rd_data[i*LANE_W +: LANE_W] = lane_drv[i] ? q : '0;

      // R6: an undriven lane reads zero
      assert_quiet_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drv[i] |-> (rd_data[i*LANE_W +: LANE_W] == '0));
    end
  endgenerate

  assign rd_drv  = lane_drv;
  assign standby = !sel;

  // R2: deselected cycles drive nothing and write nothing
  assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (rd_drv == '0 && lane_we == '0));

  // R4: drive only happens under the read condition
  assert_drive_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_drv != '0) |-> (!we_n && 1'b0 || (we_n && !oe_n && !standby)));

  // R5: output disable keeps lanes undriven while active
  assert_hiz_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby && we_n && oe_n) |-> (rd_drv == '0));

  // R7: all lanes disabled gives no drive and no write
  assert_all_lanes_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (LANE_CTRL && lane_en_n == 3'b111) |-> (rd_drv == '0 && lane_we == '0));

  // R9: no write before the synchronized reset release
  assert_no_write_in_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_ok |-> (lane_we == '0));
endmodule

// File: tb/bls_sram_core_tb.sv
module bls_sram_core_tb;
  localparam int AW = 10;

  typedef struct packed {
    logic [2:0]  cs;     // {cs_a_n, cs_b_n, cs_c}
    logic        we_n;
    logic        oe_n;
    logic [2:0]  be_n;
    logic [3:0]  addr;
    logic [23:0] wd;
    logic [2:0]  xdrv;
    logic        xstby;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{3'b101, 1'b0, 1'b0, 3'b000, 4'd1, 24'hAAAAAA, 3'b000, 1'b1}, // R2
    '{3'b011, 1'b0, 1'b0, 3'b000, 4'd1, 24'hBBBBBB, 3'b000, 1'b1}, // R2
    '{3'b000, 1'b0, 1'b0, 3'b000, 4'd1, 24'hCCCCCC, 3'b000, 1'b1}, // R2
    '{3'b001, 1'b0, 1'b1, 3'b000, 4'd1, 24'h123456, 3'b000, 1'b0}, // R3 oe_n ignored
    '{3'b001, 1'b1, 1'b0, 3'b000, 4'd1, 24'h000000, 3'b111, 1'b0}, // R4
    '{3'b001, 1'b1, 1'b0, 3'b110, 4'd1, 24'h000000, 3'b001, 1'b0}, // R4 lane0
    '{3'b001, 1'b1, 1'b0, 3'b101, 4'd1, 24'h000000, 3'b010, 1'b0}, // R4 lane1
    '{3'b001, 1'b1, 1'b0, 3'b011, 4'd1, 24'h000000, 3'b100, 1'b0}, // R4 lane2
    '{3'b001, 1'b1, 1'b1, 3'b000, 4'd1, 24'h000000, 3'b000, 1'b0}, // R5
    '{3'b001, 1'b0, 1'b0, 3'b110, 4'd2, 24'h0000AB, 3'b000, 1'b0}, // R3
    '{3'b001, 1'b0, 1'b0, 3'b101, 4'd2, 24'h00CD00, 3'b000, 1'b0}, // R3
    '{3'b001, 1'b0, 1'b0, 3'b011, 4'd2, 24'hEF0000, 3'b000, 1'b0}, // R3
    '{3'b001, 1'b1, 1'b0, 3'b000, 4'd2, 24'h000000, 3'b111, 1'b0}, // R3 readback
    '{3'b001, 1'b0, 1'b0, 3'b111, 4'd2, 24'h111111, 3'b000, 1'b0}, // R7
    '{3'b001, 1'b1, 1'b0, 3'b000, 4'd2, 24'h000000, 3'b111, 1'b0}, // R7 readback
    '{3'b000, 1'b1, 1'b0, 3'b000, 4'd2, 24'h000000, 3'b000, 1'b1}, // R2 read
    '{3'b001, 1'b0, 1'b0, 3'b010, 4'd3, 24'h778899, 3'b000, 1'b0}, // R3 two lanes
    '{3'b001, 1'b1, 1'b0, 3'b000, 4'd3, 24'h000000, 3'b111, 1'b0}, // R6 readback
    '{3'b001, 1'b1, 1'b0, 3'b111, 4'd3, 24'h000000, 3'b000, 1'b0}, // R7 read
    '{3'b101, 1'b0, 1'b0, 3'b000, 4'd3, 24'hFFFFFF, 3'b000, 1'b1}, // R2 write
    '{3'b001, 1'b1, 1'b0, 3'b000, 4'd3, 24'h000000, 3'b111, 1'b0}  // R2 readback
  };

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          cs_a_n, cs_b_n, cs_c, we_n, oe_n;
  logic [2:0]    lane_en_n;
  logic [23:0]   wr_data;
  logic [23:0]   rd_data, rd_data_nb;
  logic [2:0]    rd_drv, rd_drv_nb;
  logic          standby, standby_nb;

  int checks;
  int failures;
  bit done;

  logic [23:0] ref_m  [16];
  logic [23:0] ref_nb [16];

  bls_sram_core #(.ADDR_W(AW), .LANE_CTRL(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
    .cs_c(cs_c), .we_n(we_n), .oe_n(oe_n), .lane_en_n(lane_en_n),
    .wr_data(wr_data), .rd_data(rd_data), .rd_drv(rd_drv), .standby(standby)
  );

  bls_sram_core #(.ADDR_W(AW), .LANE_CTRL(1'b0)) u_dut_nobe (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
    .cs_c(cs_c), .we_n(we_n), .oe_n(oe_n), .lane_en_n(lane_en_n),
    .wr_data(wr_data), .rd_data(rd_data_nb), .rd_drv(rd_drv_nb), .standby(standby_nb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] cs, input logic w, input logic o,
                       input logic [2:0] be, input logic [AW-1:0] a, input logic [23:0] d);
    {cs_a_n, cs_b_n, cs_c} = cs;
    we_n = w; oe_n = o; lane_en_n = be; addr = a; wr_data = d;
  endtask

  function automatic logic [23:0] mask_drv(input logic [23:0] w, input logic [2:0] drv);
    logic [23:0] r;
    for (int l = 0; l < 3; l++) r[l*8 +: 8] = drv[l] ? w[l*8 +: 8] : 8'h00;
    return r;
  endfunction

  initial begin
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0;
    drive(3'b100, 1'b1, 1'b1, 3'b111, '0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 reset standby", {23'd0, standby}, 24'd1);
    chk("R2 reset drive", {21'd0, rd_drv}, 24'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // clear the words used by the table
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      drive(3'b001, 1'b0, 1'b1, 3'b000, AW'(a), 24'h000000);
      ref_m[a] = 24'h0; ref_nb[a] = 24'h0;
    end

    for (int i = 0; i < NV; i++) begin
      logic sel;
      logic [2:0] xnb;
      @(negedge clk);
      drive(VECS[i].cs, VECS[i].we_n, VECS[i].oe_n, VECS[i].be_n,
            AW'(VECS[i].addr), VECS[i].wd);
      #1;
      sel = (VECS[i].cs == 3'b001);
      xnb = (sel && VECS[i].we_n && !VECS[i].oe_n) ? 3'b111 : 3'b000;
      chk($sformatf("R2 standby vec%0d", i), {23'd0, standby}, {23'd0, VECS[i].xstby});
      chk($sformatf("R4 drive vec%0d", i), {21'd0, rd_drv}, {21'd0, VECS[i].xdrv});
      chk($sformatf("R6 rdata vec%0d", i), rd_data,
          mask_drv(ref_m[VECS[i].addr], VECS[i].xdrv));
      chk($sformatf("R8 drive vec%0d", i), {21'd0, rd_drv_nb}, {21'd0, xnb});
      chk($sformatf("R8 rdata vec%0d", i), rd_data_nb, mask_drv(ref_nb[VECS[i].addr], xnb));
      if (sel && !VECS[i].we_n) begin
        for (int l = 0; l < 3; l++)
          if (!VECS[i].be_n[l]) ref_m[VECS[i].addr][l*8 +: 8] = VECS[i].wd[l*8 +: 8];
        ref_nb[VECS[i].addr] = VECS[i].wd;
      end
    end

    // R1: first and last words are separate
    @(negedge clk); drive(3'b001, 1'b0, 1'b0, 3'b000, '1, 24'h5EED01);
    @(negedge clk); drive(3'b001, 1'b0, 1'b0, 3'b000, '0, 24'h0F0F0F);
    @(negedge clk); drive(3'b001, 1'b1, 1'b0, 3'b000, '1, 24'h0);
    #1 chk("R1 top word", rd_data, 24'h5EED01);
    @(negedge clk); drive(3'b001, 1'b1, 1'b0, 3'b000, '0, 24'h0);
    #1 chk("R1 word zero", rd_data, 24'h0F0F0F);

    // R9: writes blocked during reset and on the first edge after release
    @(negedge clk);
    rst_n = 1'b0;
    drive(3'b001, 1'b0, 1'b0, 3'b000, AW'(1), 24'h5A5A5A);
    #1 chk("R9 standby in reset", {23'd0, standby}, 24'd0);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    drive(3'b001, 1'b0, 1'b0, 3'b000, AW'(4), 24'hC3C3C3);
    @(negedge clk);
    drive(3'b001, 1'b1, 1'b0, 3'b000, AW'(1), 24'h0);
    #1 chk("R9 word1 kept", rd_data, ref_m[1]);
    @(negedge clk);
    drive(3'b001, 1'b1, 1'b0, 3'b000, AW'(4), 24'h0);
    #1 chk("R9 word4 kept", rd_data, 24'h000000);
    @(negedge clk);
    drive(3'b100, 1'b1, 1'b1, 3'b111, '0, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule